// File: doc/BRIEF.md
# SIR Infrared Pulse Encoder

This block turns the NRZ transmit line of an asynchronous serial port into the return-to-zero pulse train that an SIR infrared transceiver expects. It runs from a 3.6864 MHz clock. A falling edge on an idle line marks the start bit and aligns a bit-period counter to it. At the start of every bit period in which the line is low, the block emits one high pulse on the infrared output. Periods in which the line is high produce no pulse. The pulse is either a fixed six clock cycles (about 1.63 µs) at every rate or three sixteenths of the current bit period. A pulse-width select input picks between the two.

Software sets the bit period, in clock cycles, on `bit_period`. The value is 3,686,400 divided by the bit rate: 32 at 115.2 kbit/s and 384 at 9.6 kbit/s. Encoding only takes place while `data_mode` is high. An active-low indicator output is driven low for as long as a frame is in progress.

The controller has three states:
- **FS_IDLE**: waits for a start bit.
- **FS_BITS**: covers the start bit and the eight data bits.
- **FS_STOP**: covers the stop-bit period.

Its transitions are:
- **start** (FS_IDLE→FS_BITS): a falling edge arrives while data mode is enabled.
- **to_stop** (FS_BITS→FS_STOP): the boundary that ends the eighth data bit.
- **resync** (FS_STOP→FS_BITS): a falling edge arrives inside the stop period.
- **done** (FS_STOP→FS_IDLE): the stop period ends.
- **abort** (FS_BITS or FS_STOP→FS_IDLE): data mode goes low.

Top module: `sir_pulse_encoder`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, `ir_pulse` is 0 and `tx_led_n` is 1.
- R2: With `data_mode` high and the controller idle, a line that goes low (first seen low at clock edge k) starts a frame. The start-bit pulse rises at edge k+1.
- R3: Bit j of a frame occupies `bit_period` cycles starting j·`bit_period` cycles after the start bit. Bit 0 is the start bit, bits 1..8 are the data bits LSB first, and bit 9 is the stop bit. Each bit whose sampled level is 0 produces exactly one pulse at its start, and a bit at level 1 produces none.
- R4: With `wide_sel` = 0, every pulse lasts 6 clock cycles, whatever the bit period.
- R5: With `wide_sel` = 1, every pulse lasts floor(3·`bit_period`/16) cycles, for example 72 cycles at a period of 384 and 12 cycles at a period of 64.
- R6: `tx_led_n` goes low on the same edge as the start-bit pulse. It stays low through the end of the tenth bit period, and it is low whenever `ir_pulse` is high.
- R7: After ten bit periods with no new falling edge the frame ends. `tx_led_n` returns to 1 one cycle after the last period, and a line held high produces no further pulses.
- R8: A falling edge inside the stop-bit period restarts the frame timing from that edge, following the same rule as R2.
- R9: While `data_mode` is 0, no pulse is produced and `tx_led_n` is 1 from the next clock edge on. A frame in progress is abandoned, and falling edges start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.6864 MHz encoder clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_mode | input | 1 | 1 = encode, 0 = encoder held idle |
| txd_nrz | input | 1 | NRZ serial transmit line, idle high |
| bit_period | input | PER_W | Bit period in clock cycles |
| wide_sel | input | 1 | 0 = fixed 6-cycle pulse, 1 = 3/16 of bit period |
| ir_pulse | output | 1 | Return-to-zero pulse to the transceiver, active high |
| tx_led_n | output | 1 | Transmit activity indicator, active low |

## Verification
The assertions take it for granted that `bit_period` stays constant for the whole of a frame. They also assume that the period is long enough for the 6-cycle pulse, and that `data_mode` does not toggle in the middle of a pulse they measure. The bench changes the period and the width mode only while the line is idle. It uses periods of 32, 64 and 384, and it drops `data_mode` only between pulses. All line transitions are driven on falling clock edges at exact multiples of the bit period, so each expected pulse start is an integer cycle number.

// File: rtl/sir_enc_pkg.sv
package sir_enc_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // waiting for a start bit
        FS_BITS = 2'd1,   // start bit and data bits
        FS_STOP = 2'd2    // stop-bit period, resync allowed
    } frame_state_e;

endpackage

// File: rtl/sir_line_sampler.sv
// Registers the serial line and flags a high-to-low transition.
module sir_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_lvl,
    output logic line_fall
);
    logic s_now;
    logic s_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_now  <= 1'b1;
            s_prev <= 1'b1;
        end else begin
            s_now  <= line_in;
            s_prev <= s_now;
        end
    end

    assign line_lvl  = s_now;
    assign line_fall = s_prev & ~s_now;
endmodule

// File: rtl/sir_bit_clock.sv
// Cycle counter inside a bit period plus bit index within the frame.
module sir_bit_clock #(
    parameter int PER_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             boundary,
    output logic [IDX_W-1:0] bit_idx
);
    logic [PER_W-1:0] cyc_q;
    logic [IDX_W-1:0] idx_q;

    assign boundary = run && (cyc_q == (period - 1'b1));
    assign bit_idx  = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            idx_q <= '0;
        end else if (restart || !run) begin
            cyc_q <= '0;
            idx_q <= '0;
        end else if (boundary) begin
            cyc_q <= '0;
            idx_q <= idx_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/sir_pulse_shaper.sv
// Produces one pulse per fire request, width chosen by mode.
module sir_pulse_shaper #(
    parameter int PER_W     = 16,
    parameter int SHORT_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             clear,
    input  logic             wide_sel,
    input  logic [PER_W-1:0] period,
    output logic             pulse_out
);
    logic [PER_W+1:0] triple_w;
    logic [PER_W-1:0] wide_w;
    logic [PER_W-1:0] raw_w;
    logic [PER_W-1:0] width_w;
    logic [PER_W-1:0] rem_q;
    logic             pulse_q;

    // 3/16 of the bit period, rounded down
    assign triple_w = ({2'b00, period} << 1) + {2'b00, period};
    assign wide_w   = PER_W'(triple_w >> 4);
    assign raw_w    = wide_sel ? wide_w : PER_W'(SHORT_CYC);
    assign width_w  = (raw_w == '0) ? PER_W'(1) : raw_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            rem_q   <= '0;
        end else if (clear) begin
            pulse_q <= 1'b0;
            rem_q   <= '0;
        end else if (fire) begin
            pulse_q <= 1'b1;
            rem_q   <= width_w - 1'b1;
        end else if (pulse_q) begin
            if (rem_q == '0) begin
                pulse_q <= 1'b0;
            end else begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign pulse_out = pulse_q;
endmodule

// File: rtl/sir_pulse_encoder.sv
// NRZ to return-to-zero infrared pulse encoder (top).
module sir_pulse_encoder
    import sir_enc_pkg::*;
#(
    parameter int PER_W      = 16,
    parameter int SHORT_CYC  = 6,
    parameter int FRAME_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_mode,
    input  logic             txd_nrz,
    input  logic [PER_W-1:0] bit_period,
    input  logic             wide_sel,
    output logic             ir_pulse,
    output logic             tx_led_n
);
    localparam int IDX_W         = $clog2(FRAME_BITS);
    localparam int LAST_DATA_IDX = FRAME_BITS - 2;

    frame_state_e     state_q, state_nx;
    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] pulse_period;
    logic             line_lvl, line_fall;
    logic             boundary;
    logic [IDX_W-1:0] bit_idx;
    logic             restart, fire, run;

    sir_line_sampler u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (txd_nrz),
        .line_lvl  (line_lvl),
        .line_fall (line_fall)
    );

    // R2, R8: a start bit is accepted while idle or inside the stop period
    assign restart = data_mode && line_fall &&
                     ((state_q == FS_IDLE) || (state_q == FS_STOP));
    assign run     = (state_q != FS_IDLE);

    sir_bit_clock #(.PER_W(PER_W), .IDX_W(IDX_W)) u_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (run),
        .period   (period_q),
        .boundary (boundary),
        .bit_idx  (bit_idx)
    );

    // R3: pulse at the start bit and at each later boundary with the line low
    assign fire = data_mode &&
                  (restart || ((state_q == FS_BITS) && boundary && !line_lvl));
    assign pulse_period = restart ? bit_period : period_q;

    sir_pulse_shaper #(.PER_W(PER_W), .SHORT_CYC(SHORT_CYC)) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .clear     (!data_mode),
        .wide_sel  (wide_sel),
        .period    (pulse_period),
        .pulse_out (ir_pulse)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (restart) state_nx = FS_BITS;                  // start
            end
            FS_BITS: begin
                if (!data_mode) state_nx = FS_IDLE;               // abort (R9)
                else if (boundary && (bit_idx == IDX_W'(LAST_DATA_IDX)))
                    state_nx = FS_STOP;                           // to_stop
            end
            FS_STOP: begin
                if (!data_mode) state_nx = FS_IDLE;               // abort (R9)
                else if (restart) state_nx = FS_BITS;             // resync (R8)
                else if (boundary) state_nx = FS_IDLE;            // done (R7)
            end
            default: state_nx = FS_IDLE;
        endcase
    end

    // State register with the latched bit period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_IDLE;
            period_q <= '0;
        end else begin
            state_q <= state_nx;
            if (restart) period_q <= bit_period;
        end
    end

    // Outputs: R6 indicator low while a frame is active
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_led_n <= 1'b1;
        end else begin
            tx_led_n <= (state_nx == FS_IDLE);
        end
    end
endmodule

// File: rtl/sir_pulse_encoder_chk.sv
// Property checker for the pulse encoder, bound to every instance.
module sir_pulse_encoder_chk #(
    parameter int PER_W     = 16,
    parameter int SHORT_CYC = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_mode,
    input logic             wide_sel,
    input logic [PER_W-1:0] bit_period,
    input logic             ir_pulse,
    input logic             tx_led_n
);
    logic             ir_d;
    logic             wide_d;
    logic             wide_q;
    logic [PER_W-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_d   <= 1'b0;
            wide_d <= 1'b0;
            wide_q <= 1'b0;
            hi_len <= '0;
        end else begin
            ir_d   <= ir_pulse;
            wide_d <= wide_sel;
            if (ir_pulse && !ir_d) wide_q <= wide_d;
            hi_len <= ir_pulse ? hi_len + 1'b1 : '0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ir_pulse && tx_led_n))
        else $error("p_reset_quiet_r1");

    p_short_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_pulse) && $past(data_mode) && !wide_q) |-> (hi_len == PER_W'(SHORT_CYC)))
        else $error("p_short_width_r4");

    p_wide_below_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_pulse) && $past(data_mode) && wide_q) |-> (hi_len < bit_period))
        else $error("p_wide_below_period_r5");

    p_pulse_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ir_pulse |-> !tx_led_n)
        else $error("p_pulse_in_frame_r6");

    p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_mode |=> !ir_pulse)
        else $error("p_quiet_disabled_r9");

    p_led_off_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_mode |=> tx_led_n)
        else $error("p_led_off_disabled_r9");
endmodule

bind sir_pulse_encoder sir_pulse_encoder_chk #(
    .PER_W     (PER_W),
    .SHORT_CYC (SHORT_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_mode  (data_mode),
    .wide_sel   (wide_sel),
    .bit_period (bit_period),
    .ir_pulse   (ir_pulse),
    .tx_led_n   (tx_led_n)
);

// File: tb/sir_pulse_encoder_test.sv
`timescale 1ns/1ps
module sir_pulse_encoder_test;
    localparam int PER_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_mode = 1'b1;
    logic             txd_nrz = 1'b1;
    logic [PER_W-1:0] bit_period = 16'd384;
    logic             wide_sel = 1'b0;
    logic             ir_pulse;
    logic             tx_led_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    // scoreboard queues
    int q_start[$];
    int q_width[$];
    int q_wide[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sir_pulse_encoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_mode  (data_mode),
        .txd_nrz    (txd_nrz),
        .bit_period (bit_period),
        .wide_sel   (wide_sel),
        .ir_pulse   (ir_pulse),
        .tx_led_n   (tx_led_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per observed pulse
    int  mon_start = 0;
    bit  mon_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ir_pulse && !mon_prev) mon_start = cyc;
            if (!ir_pulse && mon_prev) begin
                if (q_start.size() == 0) begin
                    check("R3", "unexpected pulse at cycle", mon_start, -1);
                end else begin
                    int es, ew, ewd;
                    es  = q_start.pop_front();
                    ew  = q_width.pop_front();
                    ewd = q_wide.pop_front();
                    check("R3", "pulse start cycle", mon_start, es);
                    if (ewd != 0) check("R5", "wide pulse width", cyc - mon_start, ew);
                    else          check("R4", "short pulse width", cyc - mon_start, ew);
                end
            end
            mon_prev = ir_pulse;
        end
    end

    // Driver: called at a falling edge; pushes expected pulses, then drives bits
    task automatic send_frame(input logic [7:0] data, input int per, input bit wide,
                              input int stop_len, input bit check_end);
        logic [9:0] bits;
        int c0, w;
        bits = {1'b1, data, 1'b0};
        w  = wide ? (per * 3) / 16 : 6;
        c0 = cyc;
        for (int j = 0; j < 10; j++) begin
            if (!bits[j]) begin
                q_start.push_back(c0 + 2 + j * per);
                q_width.push_back(w);
                q_wide.push_back(wide ? 1 : 0);
            end
        end
        for (int j = 0; j < 10; j++) begin
            txd_nrz = bits[j];
            if (j == 0) begin
                repeat (2) @(negedge clk);
                check("R6", "indicator at frame start", tx_led_n, 0);
                repeat (per - 2) @(negedge clk);
            end else if (j == 9) begin
                repeat (stop_len) @(negedge clk);
            end else begin
                repeat (per) @(negedge clk);
            end
        end
        if (check_end) begin
            @(negedge clk);
            check("R6", "indicator in last frame cycle", tx_led_n, 0);
            @(negedge clk);
            check("R7", "indicator after frame end", tx_led_n, 1);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", "ir_pulse in reset", ir_pulse, 0);
        check("R1", "tx_led_n in reset", tx_led_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ir_pulse after release", ir_pulse, 0);
        check("R1", "tx_led_n after release", tx_led_n, 1);
        repeat (3) @(negedge clk);

        // R2 R3 R4: 0x06 at period 384, short pulses
        bit_period = 16'd384; wide_sel = 1'b0;
        send_frame(8'h06, 384, 1'b0, 384, 1'b1);
        repeat (10) @(negedge clk);

        // R5: same byte, 3/16 width (72 cycles)
        wide_sel = 1'b1;
        send_frame(8'h06, 384, 1'b1, 384, 1'b1);
        repeat (10) @(negedge clk);

        // R3 R4: period 32, several patterns
        bit_period = 16'd32; wide_sel = 1'b0;
        repeat (3) @(negedge clk);
        send_frame(8'h00, 32, 1'b0, 32, 1'b1);
        repeat (5) @(negedge clk);
        send_frame(8'h55, 32, 1'b0, 32, 1'b1);
        repeat (5) @(negedge clk);
        send_frame(8'hFF, 32, 1'b0, 32, 1'b1);

        // R7: line held high, no pulses, indicator inactive
        repeat (4 * 32) @(negedge clk);
        check("R7", "indicator while idle", tx_led_n, 1);
        check("R7", "pending pulses while idle", q_start.size(), 0);

        // R5: period 64, width 12; back-to-back then R8 short stop resync
        bit_period = 16'd64; wide_sel = 1'b1;
        repeat (3) @(negedge clk);
        send_frame(8'hA3, 64, 1'b1, 64, 1'b0);
        send_frame(8'h3C, 64, 1'b1, 32, 1'b0);   // stop cut short: R8
        send_frame(8'h81, 64, 1'b1, 64, 1'b1);
        repeat (10) @(negedge clk);

        // R9: abandon a frame by dropping data_mode between pulses
        wide_sel = 1'b0;
        repeat (3) @(negedge clk);
        begin
            int c0;
            c0 = cyc;
            q_start.push_back(c0 + 2);
            q_width.push_back(6);
            q_wide.push_back(0);
            txd_nrz = 1'b0;
            repeat (20) @(negedge clk);
            data_mode = 1'b0;
            @(negedge clk);
            check("R9", "indicator after disable", tx_led_n, 1);
            check("R9", "ir_pulse after disable", ir_pulse, 0);
            repeat (100) @(negedge clk);      // line low across boundaries
            txd_nrz = 1'b1;
            repeat (40) @(negedge clk);
            txd_nrz = 1'b0;                   // falling edge while disabled
            repeat (70) @(negedge clk);
            check("R9", "indicator with edge while disabled", tx_led_n, 1);
            txd_nrz = 1'b1;
            repeat (20) @(negedge clk);
            data_mode = 1'b1;
            repeat (5) @(negedge clk);
            check("R9", "indicator after re-enable", tx_led_n, 1);
        end

        // R2: normal frame after re-enable
        send_frame(8'h5A, 64, 1'b0, 64, 1'b1);
        repeat (20) @(negedge clk);
        check("R3", "unconsumed expected pulses", q_start.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule